// File: doc/BRIEF.md
# Ping-pong external RAM line delay

The block delays a pixel stream by exactly one video line and keeps the line storage off chip, in two single-port synchronous RAMs. Each RAM has one data bus that carries both write and read data. Both chips are driven by one address counter. It advances once per valid input pixel, runs from 0 to LINE_LEN-1 and then wraps to 0. During a line period one chip takes the incoming pixels. The other chip is read at the same address and returns the pixel stored one line earlier. The two chips swap roles at every wrap of the address, so neither chip is ever asked to read and write in the same cycle and each chip runs at the pixel rate.

Address, write enable, output enable and write data leave the block from registers. The bench RAMs model a synchronous write, and a read that appears on the bus while output enable is high. The returned word is captured into an output register one clock after the address is issued. Throughout the first line after reset the delayed-pixel valid stays low, because nothing has been stored yet.

Top module: `lpd_line_delay`

## Requirements
- R1: Each pixel on pix_o with pix_valid_o high equals the input pixel accepted exactly LINE_LEN (default 800) valid samples earlier. After the stream stops, the number of delayed pixels equals the number of input pixels minus LINE_LEN.
- R2: ram_addr_o is issued once per valid input pixel and runs 0, 1, …, LINE_LEN-1, then wraps to 0. It always stays below LINE_LEN.
- R3: For each valid input pixel exactly one bank is written. Bit b of ram_we_o and ram_oe_o belongs to RAM b, and both signals are active high. The written bank has its write enable high and its data bus driven with that pixel. The other bank has its output enable high, and the block does not drive its bus.
- R4: After reset the first line is written into RAM 0. The written bank changes at every address wrap and stays the same between wraps.
- R5: In a cycle where pix_valid_i is low, both write enables and both output enables are low in the following cycle. The address does not advance, and the delayed stream is unaffected by the gap.
- R6: A pixel sampled at clock edge k appears on pix_o, with pix_valid_o high, right after edge k+1. pix_valid_o is never high unless pix_valid_i was high two edges earlier.
- R7: pix_valid_o stays low for the first LINE_LEN valid pixels after reset.
- R8: While rst_ni is low, pix_o, pix_valid_o, ram_addr_o, ram_we_o and ram_oe_o are all 0. After reset is released, the blanking of R7 starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_i | input | PIX_W | Incoming pixel |
| pix_valid_i | input | 1 | Incoming pixel is valid |
| pix_o | output | PIX_W | Pixel from one line earlier |
| pix_valid_o | output | 1 | pix_o is valid |
| ram_addr_o | output | ADDR_W | Address shared by both RAMs |
| ram_we_o | output | 2 | Write enable per RAM, bit b is RAM b |
| ram_oe_o | output | 2 | Output enable per RAM, bit b is RAM b |
| ram0_data_io | inout | PIX_W | Data bus of RAM 0 |
| ram1_data_io | inout | PIX_W | Data bus of RAM 1 |

## Verification
The bench goes after the first line. A design that did not blank its output would emit one line of stale RAM contents, and a design that armed the output one pixel late would drop the first delayed pixel. It checks the swap at the wrap on every line. An off-by-one in the wrap would either make the delay LINE_LEN±1 pixels long, or make a chip read and write in the same line, which shows up as wrong pixels. Gaps of different lengths in the input valid would expose a counter that advanced on idle cycles, or a read-capture path that took a floating bus. A reset in the middle of the stream shows whether the blanking line and the RAM-0-first ordering restart.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/lpd_addr_ctrl.sv
module lpd_addr_ctrl
  import lpd_pkg::*;
#(
  parameter int unsigned LINE_LEN = 800,
  parameter int unsigned ADDR_W   = $clog2(LINE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output bank_e             wr_bank_o,
  output logic              primed_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LINE_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      wr_bank_o <= BANK_A;
      primed_o  <= 1'b0;
    end else if (adv_i) begin
      if (addr_o == LAST) begin
        addr_o    <= '0;
        wr_bank_o <= (wr_bank_o == BANK_A) ? BANK_B : BANK_A;
        primed_o  <= 1'b1;
      end else begin
        addr_o <= addr_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpd_bank_drv.sv
module lpd_bank_drv #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             sel_wr_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             we_o,
  output logic             oe_o,
  output logic [PIX_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      oe_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o <= adv_i & sel_wr_i;
      oe_o <= adv_i & ~sel_wr_i;
      if (adv_i && sel_wr_i) wdata_o <= pix_i;
    end
  end
endmodule

// File: rtl/lpd_rd_capture.sv
module lpd_rd_capture #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_vld_i,
  input  logic             rd_sel_i,
  input  logic [PIX_W-1:0] bus0_i,
  input  logic [PIX_W-1:0] bus1_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o       <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      pix_valid_o <= rd_vld_i;
      if (rd_vld_i) pix_o <= rd_sel_i ? bus1_i : bus0_i;
    end
  end
endmodule

// File: rtl/lpd_line_delay.sv
module lpd_line_delay
  import lpd_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned LINE_LEN = 800,
  parameter int unsigned ADDR_W   = $clog2(LINE_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIX_W-1:0]     pix_i,
  input  logic                 pix_valid_i,
  output logic [PIX_W-1:0]     pix_o,
  output logic                 pix_valid_o,
  output logic [ADDR_W-1:0]    ram_addr_o,
  output logic [NUM_BANKS-1:0] ram_we_o,
  output logic [NUM_BANKS-1:0] ram_oe_o,
  inout  wire  [PIX_W-1:0]     ram0_data_io,
  inout  wire  [PIX_W-1:0]     ram1_data_io
);
  logic [ADDR_W-1:0]               cnt;
  bank_e                           wr_bank;
  logic                            primed;
  logic [NUM_BANKS-1:0][PIX_W-1:0] wdata;
  logic                            rd_vld_q;
  logic                            rd_sel_q;

  lpd_addr_ctrl #(.LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (pix_valid_i),
    .addr_o    (cnt),
    .wr_bank_o (wr_bank),
    .primed_o  (primed)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lpd_bank_drv #(.PIX_W(PIX_W)) u_drv (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (pix_valid_i),
      .sel_wr_i (wr_bank == bank_e'(1'(b))),
      .pix_i    (pix_i),
      .we_o     (ram_we_o[b]),
      .oe_o     (ram_oe_o[b]),
      .wdata_o  (wdata[b])
    );
  end

  // only the bank being written is driven
  assign ram0_data_io = ram_we_o[0] ? wdata[0] : 'z;
  assign ram1_data_io = ram_we_o[1] ? wdata[1] : 'z;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      rd_vld_q   <= 1'b0;
      rd_sel_q   <= 1'b0;
    end else begin
      rd_vld_q <= pix_valid_i & primed;
      if (pix_valid_i) begin
        ram_addr_o <= cnt;
        rd_sel_q   <= (wr_bank == BANK_A);
      end
    end
  end

  lpd_rd_capture #(.PIX_W(PIX_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_vld_i    (rd_vld_q),
    .rd_sel_i    (rd_sel_q),
    .bus0_i      (ram0_data_io),
    .bus1_i      (ram1_data_io),
    .pix_o       (pix_o),
    .pix_valid_o (pix_valid_o)
  );
endmodule

// File: rtl/lpd_chk.sv
module lpd_chk #(
  parameter int unsigned LINE_LEN = 800,
  parameter int unsigned ADDR_W   = $clog2(LINE_LEN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_valid_i,
  input logic              pix_valid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [1:0]        ram_we_o,
  input logic [1:0]        ram_oe_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LINE_LEN - 1);

  logic              seen_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [1:0]        last_we_q;
  logic              issue;

  assign issue = |ram_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      last_addr_q <= '0;
      last_we_q   <= '0;
    end else if (issue) begin
      seen_q      <= 1'b1;
      last_addr_q <= ram_addr_o;
      last_we_q   <= ram_we_o;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ram_we_o)); // R3
  AST_ROLES_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> (ram_oe_o == ~ram_we_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> (ram_we_o == 2'b00 && ram_oe_o == 2'b00)); // R5
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o <= LAST); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && seen_q) |->
      (ram_addr_o == ((last_addr_q == LAST) ? '0 : last_addr_q + 1'b1))); // R2
  AST_FIRST_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && !seen_q) |-> (ram_we_o == 2'b01)); // R4
  AST_SWAP_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && seen_q && last_addr_q == LAST) |-> (ram_we_o != last_we_q)); // R4
  AST_HOLD_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && seen_q && last_addr_q != LAST) |-> (ram_we_o == last_we_q)); // R4
  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(pix_valid_i, 2)); // R6
endmodule

bind lpd_line_delay lpd_chk #(.LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_valid_o (pix_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .ram_oe_o    (ram_oe_o)
);

// File: tb/tb_lpd_line_delay.sv
module tb_lpd_line_delay;
  localparam int PIX_W  = 8;
  localparam int LEN    = 800;
  localparam int ADDR_W = $clog2(LEN);
  localparam int HIST   = 4096;
  // segment: [31:16] pixel count, [15:8] idle cycles after each pixel, [7:0] seed
  localparam int NSEG = 4;
  localparam logic [31:0] SEG [NSEG] = '{
    {16'd300, 8'd0, 8'h11},
    {16'd500, 8'd2, 8'h5A},
    {16'd700, 8'd1, 8'hC3},
    {16'd400, 8'd3, 8'h27}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic pix_valid_i = 1'b0;
  logic [PIX_W-1:0] pix_o;
  logic pix_valid_o;
  logic [ADDR_W-1:0] ram_addr;
  logic [1:0] ram_we, ram_oe;
  wire [PIX_W-1:0] bus0, bus1;

  always #4 clk = ~clk;

  lpd_line_delay #(.PIX_W(PIX_W), .LINE_LEN(LEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .ram_oe_o(ram_oe), .ram0_data_io(bus0), .ram1_data_io(bus1)
  );

  // behavioural RAMs: synchronous write, read visible while output enable is high
  logic [PIX_W-1:0] mem0 [LEN];
  logic [PIX_W-1:0] mem1 [LEN];
  always @(posedge clk) begin
    if (ram_we[0]) mem0[ram_addr] <= bus0;
    if (ram_we[1]) mem1[ram_addr] <= bus1;
  end
  assign bus0 = ram_oe[0] ? mem0[ram_addr] : 'z;
  assign bus1 = ram_oe[1] ? mem1[ram_addr] : 'z;

  int n_tests = 0;
  int n_fail = 0;
  int n_in = 0;
  int n_out = 0;
  int mon_en = 0;
  logic [PIX_W-1:0] sent [HIST];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // delayed-stream scoreboard
  always @(negedge clk) begin
    if (mon_en != 0 && rst_n && pix_valid_o) begin
      check(n_in > LEN, "R7", "output valid during first line", n_in, LEN + 1);
      check(pix_o == sent[n_out % HIST], "R1", "delayed pixel",
            int'(pix_o), int'(sent[n_out % HIST]));
      n_out++;
    end
  end

  // called at a negedge; returns at the next negedge
  task automatic drive(input logic [PIX_W-1:0] d);
    int bank;
    bank = (n_in / LEN) % 2;
    pix_i = d;
    pix_valid_i = 1'b1;
    sent[n_in % HIST] = d;
    @(negedge clk);
    pix_valid_i = 1'b0;
    check(ram_we == (2'b01 << bank), "R4", "write bank", int'(ram_we), 1 << bank);
    check(ram_oe == (2'b10 >> bank), "R3", "read bank enable", int'(ram_oe), 2 >> bank);
    check(int'(ram_addr) == n_in % LEN, "R2", "address", int'(ram_addr), n_in % LEN);
    check((bank == 0 ? bus0 : bus1) == d, "R3", "write bus data",
          int'(bank == 0 ? bus0 : bus1), int'(d));
    n_in++;
  endtask

  task automatic idle(input int n);
    logic [ADDR_W-1:0] a;
    a = ram_addr;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(ram_we == 2'b00 && ram_oe == 2'b00, "R5", "idle enables",
            int'({ram_we, ram_oe}), 0);
      check(ram_addr == a, "R5", "idle address hold", int'(ram_addr), int'(a));
    end
  endtask

  task automatic reset_check();
    check(pix_o == '0 && pix_valid_o == 1'b0, "R8", "reset outputs",
          int'({pix_valid_o, pix_o}), 0);
    check(ram_we == 2'b00 && ram_oe == 2'b00 && ram_addr == '0, "R8",
          "reset ram controls", int'({ram_we, ram_oe, ram_addr}), 0);
  endtask

  task automatic first_line(input logic [PIX_W-1:0] seed);
    for (int i = 0; i < LEN; i++) drive(PIX_W'(i * 13) + seed);
    drive(8'hA5);
    check(pix_valid_o == 1'b0, "R6", "valid one edge after sample", int'(pix_valid_o), 0);
    @(negedge clk);
    check(pix_valid_o == 1'b1, "R6", "valid two edges after sample", int'(pix_valid_o), 1);
    check(pix_o == sent[0], "R6", "first delayed pixel", int'(pix_o), int'(sent[0]));
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;

    first_line(8'h03);

    for (int s = 0; s < NSEG; s++) begin
      for (int i = 0; i < int'(SEG[s][31:16]); i++) begin
        drive(PIX_W'(n_in * 13) + SEG[s][7:0]);
        if (SEG[s][15:8] != 0) idle(int'(SEG[s][15:8]));
      end
    end
    idle(4);
    check(n_out == n_in - LEN, "R1", "delayed pixel count", n_out, n_in - LEN);

    // reset in mid-stream, then blanking must restart
    pix_i = 8'h77;
    pix_valid_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    pix_valid_i = 1'b0;
    @(negedge clk);
    reset_check();
    mon_en = 0;
    n_in = 0;
    n_out = 0;
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;
    first_line(8'h5C);
    idle(3);
    check(n_out == n_in - LEN, "R8", "count after re-reset", n_out, n_in - LEN);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule